// File: doc/BRIEF.md
# Secondary Status Write Command Handler

This block is the command front end of a serial memory slave for one command: a write that updates two protection bits of a secondary status register. Select, serial clock and serial data in arrive already synchronised to the system clock. The block finds the rising serial-clock edges inside a selected frame and counts the bits. It shifts in an opcode and then one data byte. The new values are applied only when select is released, and only if the frame ended cleanly on a byte boundary.

A write-enable latch gates the command. A separate one-byte enable command sets the latch, and every attempt at the write clears it again, whether the write succeeds or aborts. An input flag marks the lockdown state as frozen; while it is set, the lockdown bit cannot change, but the reset-enable bit still updates. The serial data output is never driven by this block.

The control FSM has six states:
- `ST_IDLE`: select is high.
- `ST_OPC`: the opcode is shifting in.
- `ST_DATA`: the write opcode (0x31) was seen and the data byte is shifting in.
- `ST_TAIL`: the data byte is complete; any further bits are discarded.
- `ST_WREN`: the enable opcode (0x06) was seen.
- `ST_SKIP`: any other opcode was seen.

Transitions:
- select low: `ST_IDLE` to `ST_OPC`.
- eighth bit of the opcode: `ST_OPC` to `ST_DATA`, `ST_WREN` or `ST_SKIP`, by opcode.
- eighth data bit: `ST_DATA` to `ST_TAIL`.
- select high: any state to `ST_IDLE`. This transition is also where the commit or abort is decided, from the state being left.

Top module: `sreg2_write_ctrl`

## Requirements
- R1: After reset, `soft_reset_en`, `lockdown_en` and `wr_latch` are 0.
- R2: A frame whose first byte is 0x06 (MSB first) and whose total bit count is a multiple of 8 sets `wr_latch` to 1 at select release. With any other bit count, `wr_latch` is left unchanged.
- R3: A frame of opcode 0x31 and a data byte, sent with `wr_latch`=1 and ending on a byte boundary, loads data bit 4 into `soft_reset_en` and data bit 3 into `lockdown_en`, and clears `wr_latch`. Data bits 7:5 and 2:0 have no effect.
- R4: `soft_reset_en`, `lockdown_en` and `wr_latch` do not change while select (`cs_n`) is low. They only change on the clock after select rises.
- R5: While `lock_frozen` is 1, a successful write leaves `lockdown_en` unchanged but still updates `soft_reset_en`.
- R6: A 0x31 frame sent while `wr_latch`=0 changes neither status bit.
- R7: Bytes after the first data byte are ignored; only the first data byte supplies the new values.
- R8: If select rises before all eight data bits have arrived, both status bits keep their values and `wr_latch` is cleared.
- R9: If select rises after the data byte at a bit count that is not a multiple of 8, both status bits keep their values and `wr_latch` is cleared.
- R10: A frame with any opcode other than 0x31 or 0x06 changes none of the three outputs.
- R11: `dout_oe` stays 0 at all times, so the serial output is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronised |
| sck | input | 1 | Serial clock, synchronised; data sampled on its rising edge |
| si | input | 1 | Serial data in, MSB first |
| lock_frozen | input | 1 | 1 = lockdown bit may not change |
| dout_oe | output | 1 | Serial output drive enable, always 0 |
| soft_reset_en | output | 1 | Reset-enable status bit |
| lockdown_en | output | 1 | Sector lockdown status bit |
| wr_latch | output | 1 | Write-enable latch |

## Verification
All 256 data byte values are swept, each with a freeze setting taken from two of the byte's own bits. This separates the two live data bits from the six ignored ones, and reset-enable from lockdown under freeze. Every sixteenth sweep step skips the enable frame, which shows the latch gating the write. Directed frames then cover the abort cases:
- select released mid data byte;
- select released off a byte boundary after the data byte;
- an enable frame with stray bits;
- an unknown opcode;
- extra trailing bytes.

Each is told apart by whether the latch is cleared, set or kept.

// File: rtl/sreg2_pkg.sv
package sreg2_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_DATA,
        ST_TAIL,
        ST_WREN,
        ST_SKIP
    } sreg2_state_e;

    localparam logic [7:0] OPC_WRITE_SR2 = 8'h31;
    localparam logic [7:0] OPC_WR_ENABLE = 8'h06;
endpackage

// File: rtl/sreg2_edge_detect.sv
module sreg2_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic cs_rise
);
    logic sck_q;
    logic cs_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            sck_q  <= sck;
            cs_n_q <= cs_n;
        end
    end

    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign cs_rise  = cs_n & ~cs_n_q;
endmodule

// File: rtl/sreg2_frame_shifter.sv
module sreg2_frame_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              si,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              aligned
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    assign byte_val  = {shreg[BYTE_W-2:0], si};
    assign byte_done = sck_rise && (bit_cnt == LAST_BIT);
    assign aligned   = (bit_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (cs_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sck_rise) begin
            shreg   <= byte_val;
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    // a completed byte always leaves the counter on a boundary (framing, R9)
    assert_byte_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !cs_n) |=> aligned);
endmodule

// File: rtl/sreg2_cmd_fsm.sv
module sreg2_cmd_fsm
    import sreg2_pkg::*;
#(
    parameter int         BYTE_W     = 8,
    parameter int         RST_BIT    = 4,
    parameter int         LOCK_BIT   = 3,
    parameter logic [7:0] OP_WRITE   = OPC_WRITE_SR2,
    parameter logic [7:0] OP_ENABLE  = OPC_WR_ENABLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cs_rise,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              aligned,
    input  logic              lock_frozen,
    output logic              dout_oe,
    output logic              soft_reset_en,
    output logic              lockdown_en,
    output logic              wr_latch
);
    sreg2_state_e state, state_nx;
    logic         pend_rst;
    logic         pend_lock;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (cs_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_OPC;
                ST_OPC: begin
                    if (byte_done) begin
                        if (byte_val == BYTE_W'(OP_WRITE))       state_nx = ST_DATA;
                        else if (byte_val == BYTE_W'(OP_ENABLE)) state_nx = ST_WREN;
                        else                                     state_nx = ST_SKIP;
                    end
                end
                ST_DATA: if (byte_done) state_nx = ST_TAIL;
                ST_TAIL, ST_WREN, ST_SKIP: state_nx = state;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs: capture the data byte, commit or abort on select release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_rst      <= 1'b0;
            pend_lock     <= 1'b0;
            soft_reset_en <= 1'b0;
            lockdown_en   <= 1'b0;
            wr_latch      <= 1'b0;
        end else begin
            if (state == ST_DATA && byte_done && !cs_n) begin
                pend_rst  <= byte_val[RST_BIT];
                pend_lock <= byte_val[LOCK_BIT];
            end
            if (cs_rise) begin
                unique case (state)
                    ST_TAIL: begin
                        if (aligned && wr_latch) begin
                            soft_reset_en <= pend_rst;
                            if (!lock_frozen) lockdown_en <= pend_lock;
                        end
                        wr_latch <= 1'b0;
                    end
                    ST_DATA: wr_latch <= 1'b0;
                    ST_WREN: if (aligned) wr_latch <= 1'b1;
                    ST_IDLE, ST_OPC, ST_SKIP: ;
                    default: ;
                endcase
            end
        end
    end

    assign dout_oe = 1'b0;

    assert_hold_while_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> $stable({soft_reset_en, lockdown_en, wr_latch}));

    assert_latch_cleared_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && state == ST_TAIL) |=> !wr_latch);

    assert_frozen_lock_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_frozen |=> $stable(lockdown_en));

    assert_no_write_without_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_latch |=> $stable({soft_reset_en, lockdown_en}));

    assert_misframed_keeps_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !aligned) |=> $stable({soft_reset_en, lockdown_en}));

    assert_enable_sets_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && state == ST_WREN && aligned) |=> wr_latch);
endmodule

// File: rtl/sreg2_write_ctrl.sv
module sreg2_write_ctrl #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic lock_frozen,
    output logic dout_oe,
    output logic soft_reset_en,
    output logic lockdown_en,
    output logic wr_latch
);
    logic              sck_rise;
    logic              cs_rise;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              aligned;

    sreg2_edge_detect u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .cs_rise  (cs_rise)
    );

    sreg2_frame_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck_rise  (sck_rise),
        .si        (si),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .aligned   (aligned)
    );

    sreg2_cmd_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .cs_rise       (cs_rise),
        .byte_done     (byte_done),
        .byte_val      (byte_val),
        .aligned       (aligned),
        .lock_frozen   (lock_frozen),
        .dout_oe       (dout_oe),
        .soft_reset_en (soft_reset_en),
        .lockdown_en   (lockdown_en),
        .wr_latch      (wr_latch)
    );
endmodule

// File: tb/sreg2_write_ctrl_tb.sv
module sreg2_write_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic lock_frozen = 1'b0;
    logic dout_oe, soft_reset_en, lockdown_en, wr_latch;

    int checks = 0;
    int fails = 0;
    bit oe_seen = 1'b0;
    bit finished = 1'b0;
    logic e_rst = 1'b0, e_lock = 1'b0, e_wel = 1'b0;

    always #4 clk = ~clk;

    sreg2_write_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .lock_frozen(lock_frozen), .dout_oe(dout_oe),
        .soft_reset_en(soft_reset_en), .lockdown_en(lockdown_en), .wr_latch(wr_latch)
    );

    always @(negedge clk) if (rst_n && dout_oe !== 1'b0) oe_seen = 1'b1;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " soft_reset_en"}, soft_reset_en, e_rst);
        chk({req, " lockdown_en"}, lockdown_en, e_lock);
        chk({req, " wr_latch"}, wr_latch, e_wel);
    endtask

    task automatic sel;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic desel;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            si = v[i];
            repeat (2) @(negedge clk);
            sck = 1'b1;
            repeat (2) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic enable_frame;
        sel(); send_bits(8'h06, 8); desel();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_all("R1 reset");

        // R6: write without latch
        sel(); send_bits(8'h31, 8); send_bits(8'h18, 8); desel();
        chk_all("R6 no latch");

        // R2: enable sets latch
        enable_frame(); e_wel = 1'b1;
        chk_all("R2 enable");

        // R10: unknown opcode keeps everything
        sel(); send_bits(8'hA5, 8); send_bits(8'h18, 8); desel();
        chk_all("R10 other opcode");

        // R8: release mid data byte
        sel(); send_bits(8'h31, 8); send_bits(8'h1F, 4); desel(); e_wel = 1'b0;
        chk_all("R8 short data");

        // R2: enable frame with stray bits does not set latch
        sel(); send_bits(8'h06, 8); send_bits(8'h00, 3); desel();
        chk_all("R2 misframed enable");

        // R9: off-boundary release after data byte
        enable_frame(); e_wel = 1'b1;
        sel(); send_bits(8'h31, 8); send_bits(8'h18, 8); send_bits(8'h00, 5); desel(); e_wel = 1'b0;
        chk_all("R9 off boundary");

        // R7: trailing bytes ignored
        enable_frame();
        sel(); send_bits(8'h31, 8); send_bits(8'h10, 8); send_bits(8'h08, 8); send_bits(8'hFF, 8); desel();
        e_rst = 1'b1; e_lock = 1'b0; e_wel = 1'b0;
        chk_all("R7 trailing bytes");

        // R3/R4/R5/R6 sweep over every data byte
        for (int d = 0; d < 256; d++) begin
            logic [7:0] b;
            logic with_en;
            b = 8'(d);
            with_en = (b[3:0] != 4'h7);
            lock_frozen = b[0] ^ b[5];
            if (with_en) begin
                enable_frame(); e_wel = 1'b1;
            end
            sel(); send_bits(8'h31, 8); send_bits(b, 8);
            repeat (2) @(negedge clk);
            chk_all("R4 held while selected");
            desel();
            if (with_en) begin
                e_rst = b[4];
                if (!lock_frozen) e_lock = b[3];
            end
            e_wel = 1'b0;
            chk_all(with_en ? (lock_frozen ? "R5 frozen write" : "R3 write") : "R6 sweep no latch");
        end
        lock_frozen = 1'b0;

        checks++;
        if (oe_seen) begin
            fails++;
            $display("FAIL R11 dout_oe: got 1 expected 0");
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule